// File: doc/BRIEF.md
# I2C Master Interrupt and Abort Status Unit

This block gathers the event pulses of an I2C master's bus engine and FIFOs into a raw status register. A software-written enable mask gates that register into a masked view and a single interrupt line. Almost every status bit is cleared as a side effect of reading a dedicated address. Writes never clear status. Software can therefore poll the raw view freely and acknowledge events only when it chooses to.

A transmit abort needs more state than a single status bit. The reason code carried by the abort-cause pulses is latched into a cause register and stays there until software acknowledges the abort. From the abort until that acknowledgement, an output holds the transmit FIFO in reset. A two-state machine tracks this. In state `ABT_FREE` no abort is pending. The transition `arm` (an abort pulse) moves it to `ABT_HELD`. From `ABT_HELD`, the transition `release` (an abort-clear or clear-all read with no abort pulse in the same cycle) returns it to `ABT_FREE`. Otherwise the machine stays in `ABT_HELD`, which is the `stay` transition.

The register port is a strobe interface. Read data is combinational and valid in the same cycle as `rd_en`. Any clearing caused by that read takes effect at the following clock edge. Word addresses: 0 raw status, 1 mask, 2 masked status, 3 clear-all, 4 clear RX underflow, 5 clear RX overflow, 6 clear TX overflow, 7 clear abort, 8 abort cause.

Top module: `i2c_irq_unit`

## Requirements
- R1: After reset the mask, every event-held status bit, the abort-cause register, `irq` and `txfifo_hold` are all zero.
- R2: Status bit layout: bit 0 RX underflow, 1 RX overflow, 2 TX overflow, 3 TX empty, 4 RX full, 5 TX abort, 6 start seen, 7 stop seen. A pulse on an event input sets its bit one clock later, whatever the mask holds.
- R3: The mask (address 1, bits 7:0, read/write) gates status: address 2 returns raw AND mask and `irq` is the OR of those bits. An all-zero mask holds `irq` low while raw status keeps updating.
- R4: Reading address 0 has no side effect; start-seen and stop-seen stay set until a clear-all read, so both can be observed together.
- R5: Reading address 4, 5 or 6 clears only the RX underflow, RX overflow or TX overflow bit respectively.
- R6: Abort causes latch into address 8, bits ORed as they arrive and kept until cleared: bit 0 no ACK on 7-bit address, 1 no ACK on first 10-bit address byte, 2 no ACK on second 10-bit address byte, 3 no ACK on data, 4 no ACK on general call, 5 general call followed by a read, 6 START byte acknowledged, 7 start requested with restart disabled, 8 10-bit read with restart disabled, 9 arbitration lost, 10 abort requested by software.
- R7: Reading address 7 clears the TX abort bit and the whole cause register, and drops `txfifo_hold`.
- R8: `txfifo_hold` rises one clock after a TX abort pulse and stays high until an abort-clearing read.
- R9: Reading address 3 clears every event-held bit (mask 0xE7, including start and stop seen and TX abort), the cause register and `txfifo_hold`.
- R10: An event pulse in the same cycle as a read that clears its bit wins: the bit (and for an abort, the new cause and the hold) ends up set.
- R11: Bits 3 and 4 follow the `txe_lvl` and `rxf_lvl` inputs directly and no read clears them.
- R12: Clear addresses return the bits they clear, as they were before the clear: address 3 returns raw AND 0xE7, addresses 4 to 7 return the single bit in bit 0. Unmapped addresses read zero, and a write to any address other than 1 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe; clear side effects occur at the next edge |
| wr_en | input | 1 | Write strobe |
| addr | input | 4 | Word address |
| wr_data | input | 8 | Write data (mask bits) |
| rd_data | output | DATA_W | Combinational read data |
| rxu_p | input | 1 | RX underflow event pulse |
| rxo_p | input | 1 | RX overflow event pulse |
| txo_p | input | 1 | TX overflow event pulse |
| abort_p | input | 1 | TX abort event pulse |
| start_p | input | 1 | Start condition seen pulse |
| stop_p | input | 1 | Stop condition seen pulse |
| txe_lvl | input | 1 | TX FIFO at or below threshold level |
| rxf_lvl | input | 1 | RX FIFO at or above threshold level |
| cause_p | input | CAUSE_W | Abort cause pulses |
| irq | output | 1 | Interrupt request |
| txfifo_hold | output | 1 | Holds the TX FIFO in reset after an abort |

## Verification
The assertions assume that `rd_en` and `wr_en` are never high together, and that event and cause pulses are single-cycle and synchronous to `clk`. They do not assume that cause pulses coincide with an abort pulse. The stimulus therefore fires cause bits both alongside and apart from `abort_p`. Every strobe is driven for exactly one cycle, and the bench never overlaps a read and a write. The only deliberate overlap is between a clearing read and an event pulse, which is used to exercise the set-wins rule.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

    localparam int NSRC   = 8;
    localparam int ADDR_W = 4;

    // status bit positions
    localparam int B_RXU = 0;
    localparam int B_RXO = 1;
    localparam int B_TXO = 2;
    localparam int B_TXE = 3;
    localparam int B_RXF = 4;
    localparam int B_ABT = 5;
    localparam int B_STA = 6;
    localparam int B_STO = 7;

    // bits that a clear-all read acts on
    localparam logic [NSRC-1:0] CLEARABLE = 8'hE7;

    // register word addresses
    localparam logic [ADDR_W-1:0] A_RAW     = 4'd0;
    localparam logic [ADDR_W-1:0] A_MASK    = 4'd1;
    localparam logic [ADDR_W-1:0] A_MASKED  = 4'd2;
    localparam logic [ADDR_W-1:0] A_CLR_ALL = 4'd3;
    localparam logic [ADDR_W-1:0] A_CLR_RXU = 4'd4;
    localparam logic [ADDR_W-1:0] A_CLR_RXO = 4'd5;
    localparam logic [ADDR_W-1:0] A_CLR_TXO = 4'd6;
    localparam logic [ADDR_W-1:0] A_CLR_ABT = 4'd7;
    localparam logic [ADDR_W-1:0] A_CAUSE   = 4'd8;

    typedef struct packed {
        logic all;
        logic rxu;
        logic rxo;
        logic txo;
        logic abt;
    } clr_req_t;

    typedef enum logic {
        ABT_FREE = 1'b0,
        ABT_HELD = 1'b1
    } abt_state_e;

endpackage

// File: rtl/i2c_irq_raw.sv
module i2c_irq_raw
    import i2c_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rxu_p,
    input  logic            rxo_p,
    input  logic            txo_p,
    input  logic            abort_p,
    input  logic            start_p,
    input  logic            stop_p,
    input  logic            txe_lvl,
    input  logic            rxf_lvl,
    input  clr_req_t        clr_i,
    output logic [NSRC-1:0] raw_o
);

    logic [NSRC-1:0] set_v;

    // pulses for held bits, levels for the two threshold bits
    assign set_v = {stop_p, start_p, abort_p, rxf_lvl, txe_lvl, txo_p, rxo_p, rxu_p};

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        if (i == B_TXE || i == B_RXF) begin : g_lvl
            assign raw_o[i] = set_v[i];
        end else begin : g_held
            logic bit_q;
            logic clr_b;

            assign clr_b = clr_i.all
                         | (clr_i.rxu && i == B_RXU)
                         | (clr_i.rxo && i == B_RXO)
                         | (clr_i.txo && i == B_TXO)
                         | (clr_i.abt && i == B_ABT);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bit_q <= 1'b0;
                end else begin
                    bit_q <= set_v[i] | (bit_q & ~clr_b);
                end
            end

            assign raw_o[i] = bit_q;

            // R10
            set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                set_v[i] |=> raw_o[i]);

            // R5
            clr_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_b && !set_v[i]) |=> !raw_o[i]);
        end
    end

endmodule

// File: rtl/i2c_irq_abort.sv
module i2c_irq_abort
    import i2c_irq_pkg::*;
#(
    parameter int CAUSE_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               abort_p,
    input  logic [CAUSE_W-1:0] cause_p,
    input  clr_req_t           clr_i,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               hold_o
);

    abt_state_e         st_q;
    abt_state_e         st_d;
    logic               rel;
    logic [CAUSE_W-1:0] cause_q;

    assign rel = clr_i.abt | clr_i.all;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ABT_FREE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state: arm, release, stay
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ABT_FREE: if (abort_p)          st_d = ABT_HELD;
            ABT_HELD: if (rel && !abort_p)  st_d = ABT_FREE;
            default:                        st_d = ABT_FREE;
        endcase
    end

    // outputs
    always_comb begin
        hold_o = (st_q == ABT_HELD);
    end

    // cause latch, new causes win over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q <= '0;
        end else begin
            cause_q <= cause_p | (cause_q & ~{CAUSE_W{rel}});
        end
    end

    assign cause_o = cause_q;

    // R8
    hold_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_p |=> hold_o);

    // R7
    hold_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel && !abort_p) |=> !hold_o);

    // R6
    cause_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rel |=> ((cause_o & $past(cause_o)) == $past(cause_o)));

endmodule

// File: rtl/i2c_irq_regs.sv
module i2c_irq_regs
    import i2c_irq_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int CAUSE_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [NSRC-1:0]    wr_data,
    input  logic [NSRC-1:0]    raw_i,
    input  logic [CAUSE_W-1:0] cause_i,
    output logic [DATA_W-1:0]  rd_data,
    output logic [NSRC-1:0]    mask_o,
    output clr_req_t           clr_o
);

    logic [NSRC-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_en && addr == A_MASK) begin
            mask_q <= wr_data;
        end
    end

    assign mask_o = mask_q;

    // clear requests decoded from the read strobe
    always_comb begin
        clr_o.all = rd_en && (addr == A_CLR_ALL);
        clr_o.rxu = rd_en && (addr == A_CLR_RXU);
        clr_o.rxo = rd_en && (addr == A_CLR_RXO);
        clr_o.txo = rd_en && (addr == A_CLR_TXO);
        clr_o.abt = rd_en && (addr == A_CLR_ABT);
    end

    always_comb begin
        rd_data = '0;
        unique case (addr)
            A_RAW:     rd_data = DATA_W'(raw_i);
            A_MASK:    rd_data = DATA_W'(mask_q);
            A_MASKED:  rd_data = DATA_W'(raw_i & mask_q);
            A_CLR_ALL: rd_data = DATA_W'(raw_i & CLEARABLE);
            A_CLR_RXU: rd_data = DATA_W'(raw_i[B_RXU]);
            A_CLR_RXO: rd_data = DATA_W'(raw_i[B_RXO]);
            A_CLR_TXO: rd_data = DATA_W'(raw_i[B_TXO]);
            A_CLR_ABT: rd_data = DATA_W'(raw_i[B_ABT]);
            A_CAUSE:   rd_data = DATA_W'(cause_i);
            default:   rd_data = '0;
        endcase
    end

    // R12
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == A_MASK) |=> $stable(mask_o));

endmodule

// File: rtl/i2c_irq_unit.sv
module i2c_irq_unit
    import i2c_irq_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int CAUSE_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic               wr_en,
    input  logic [3:0]         addr,
    input  logic [7:0]         wr_data,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               rxu_p,
    input  logic               rxo_p,
    input  logic               txo_p,
    input  logic               abort_p,
    input  logic               start_p,
    input  logic               stop_p,
    input  logic               txe_lvl,
    input  logic               rxf_lvl,
    input  logic [CAUSE_W-1:0] cause_p,
    output logic               irq,
    output logic               txfifo_hold
);

    logic [NSRC-1:0]    raw_w;
    logic [NSRC-1:0]    mask_w;
    logic [CAUSE_W-1:0] cause_w;
    clr_req_t           clr_w;

    i2c_irq_regs #(.DATA_W(DATA_W), .CAUSE_W(CAUSE_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .raw_i   (raw_w),
        .cause_i (cause_w),
        .rd_data (rd_data),
        .mask_o  (mask_w),
        .clr_o   (clr_w)
    );

    i2c_irq_raw u_raw (
        .clk     (clk),
        .rst_n   (rst_n),
        .rxu_p   (rxu_p),
        .rxo_p   (rxo_p),
        .txo_p   (txo_p),
        .abort_p (abort_p),
        .start_p (start_p),
        .stop_p  (stop_p),
        .txe_lvl (txe_lvl),
        .rxf_lvl (rxf_lvl),
        .clr_i   (clr_w),
        .raw_o   (raw_w)
    );

    i2c_irq_abort #(.CAUSE_W(CAUSE_W)) u_abort (
        .clk     (clk),
        .rst_n   (rst_n),
        .abort_p (abort_p),
        .cause_p (cause_p),
        .clr_i   (clr_w),
        .cause_o (cause_w),
        .hold_o  (txfifo_hold)
    );

    assign irq = |(raw_w & mask_w);

    // R3
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_w == '0) |-> !irq);

    // R8
    hold_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txfifo_hold |-> raw_w[B_ABT]);

endmodule

// File: tb/test_i2c_irq_unit.sv
`timescale 1ns/1ps
module test_i2c_irq_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] rd_data;
    logic [7:0]  ev = '0;
    logic        txe_lvl = 1'b0;
    logic        rxf_lvl = 1'b0;
    logic [10:0] cause_p = '0;
    logic        irq;
    logic        txfifo_hold;

    int errs = 0;
    int checks = 0;
    bit done = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    i2c_irq_unit i_i2c_irq_unit (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data),
        .rxu_p(ev[0]), .rxo_p(ev[1]), .txo_p(ev[2]), .abort_p(ev[5]),
        .start_p(ev[6]), .stop_p(ev[7]), .txe_lvl(txe_lvl), .rxf_lvl(rxf_lvl),
        .cause_p(cause_p), .irq(irq), .txfifo_hold(txfifo_hold)
    );

    // monitor: compare read data against scoreboard
    always @(negedge clk) begin
        if (rd_en) begin
            logic [15:0] e;
            string t;
            if (exp_q.size() == 0) begin
                errs++; checks++;
                $display("FAIL scoreboard: read with no expected item, actual %h expected none", rd_data);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (rd_data !== e) begin
                    errs++;
                    $display("FAIL %s: actual %h expected %h", t, rd_data, e);
                end
            end
        end
    end

    task automatic rd_ev(input logic [3:0] a, input logic [15:0] e, input string t,
                         input logic [7:0] evv, input logic [10:0] cv);
        @(posedge clk); #1;
        addr = a; rd_en = 1'b1; ev = evv; cause_p = cv;
        exp_q.push_back(e); tag_q.push_back(t);
        @(posedge clk); #1;
        rd_en = 1'b0; ev = '0; cause_p = '0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [15:0] e, input string t);
        rd_ev(a, e, t, 8'h00, 11'h000);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic fire(input logic [7:0] evv, input logic [10:0] cv);
        @(posedge clk); #1;
        ev = evv; cause_p = cv;
        @(posedge clk); #1;
        ev = '0; cause_p = '0;
    endtask

    task automatic chk1(input string t, input logic act, input logic e);
        checks++;
        if (act !== e) begin
            errs++;
            $display("FAIL %s: actual %b expected %b", t, act, e);
        end
    endtask

    task automatic chk_out(input string t, input logic ei, input logic eh);
        @(negedge clk);
        chk1({t, " irq"}, irq, ei);
        chk1({t, " hold"}, txfifo_hold, eh);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk_out("R1 reset", 1'b0, 1'b0);
        rd(4'd0, 16'h0000, "R1 raw after reset");
        rd(4'd1, 16'h0000, "R1 mask after reset");
        rd(4'd8, 16'h0000, "R1 cause after reset");

        // R2 events set bits with mask zero
        fire(8'h41, 11'h0);
        rd(4'd0, 16'h0041, "R2 raw rxu+start");
        rd(4'd2, 16'h0000, "R3 masked with zero mask");
        chk_out("R3 mask zero", 1'b0, 1'b0);
        // R4 raw read repeats without side effect
        rd(4'd0, 16'h0041, "R4 raw reread");

        // R3 mask opens interrupt
        wr(4'd1, 8'hFF);
        chk_out("R3 mask all", 1'b1, 1'b0);
        rd(4'd2, 16'h0041, "R3 masked all");
        wr(4'd1, 8'h02);
        chk_out("R3 mask rxo only", 1'b0, 1'b0);
        fire(8'h02, 11'h0);
        chk_out("R3 rxo fires irq", 1'b1, 1'b0);
        rd(4'd2, 16'h0002, "R3 masked rxo");
        rd(4'd0, 16'h0043, "R2 raw rxo");

        // R5 per-source clears, R12 return value
        rd(4'd4, 16'h0001, "R12 clr rxu return");
        rd(4'd0, 16'h0042, "R5 rxu only cleared");
        rd(4'd5, 16'h0001, "R12 clr rxo return");
        rd(4'd0, 16'h0040, "R5 rxo only cleared");
        fire(8'h04, 11'h0);
        rd(4'd0, 16'h0044, "R2 raw txo");
        rd(4'd6, 16'h0001, "R12 clr txo return");
        rd(4'd0, 16'h0040, "R5 txo only cleared");

        // R4 start and stop visible together
        fire(8'h80, 11'h0);
        rd(4'd0, 16'h00C0, "R4 start and stop held");

        // R8 abort with causes, R6 latch
        wr(4'd1, 8'h00);
        fire(8'h20, 11'h208);
        chk_out("R8 hold after abort", 1'b0, 1'b1);
        rd(4'd0, 16'h00E0, "R2 raw abort");
        rd(4'd8, 16'h0208, "R6 causes latched");
        fire(8'h00, 11'h001);
        rd(4'd8, 16'h0209, "R6 causes accumulate");
        chk_out("R8 hold persists", 1'b0, 1'b1);

        // R7 abort clear
        rd(4'd7, 16'h0001, "R12 clr abort return");
        chk_out("R7 hold released", 1'b0, 1'b0);
        rd(4'd8, 16'h0000, "R7 causes cleared");
        rd(4'd0, 16'h00C0, "R7 abort bit cleared");

        // R10 set wins over clear
        rd_ev(4'd4, 16'h0000, "R10 clr rxu return", 8'h01, 11'h0);
        rd(4'd0, 16'h00C1, "R10 rxu survives clear");
        rd_ev(4'd7, 16'h0000, "R10 clr abort return", 8'h20, 11'h400);
        chk_out("R10 hold survives clear", 1'b0, 1'b1);
        rd(4'd8, 16'h0400, "R10 cause survives clear");

        // R11 level bit, R9 clear-all
        txe_lvl = 1'b1;
        rd(4'd0, 16'h00E9, "R11 txe level visible");
        rd(4'd3, 16'h00E1, "R12 clr all return");
        rd(4'd0, 16'h0008, "R9 all held bits cleared, R11 level kept");
        chk_out("R9 hold released", 1'b0, 1'b0);
        rd(4'd8, 16'h0000, "R9 causes cleared");
        txe_lvl = 1'b0; rxf_lvl = 1'b1;
        rd(4'd0, 16'h0010, "R11 rxf follows level");
        rd(4'd3, 16'h0000, "R12 clr all with only level");
        rd(4'd0, 16'h0010, "R11 rxf not cleared by read");

        // R3 zero mask blocks but raw updates
        fire(8'h01, 11'h0);
        chk_out("R3 zero mask blocks", 1'b0, 1'b0);
        rd(4'd0, 16'h0011, "R3 raw updates under zero mask");
        wr(4'd1, 8'h10);
        chk_out("R11 level drives irq", 1'b1, 1'b0);
        rd(4'd2, 16'h0010, "R11 masked level");

        // R12 unmapped read and ignored write
        rd(4'd15, 16'h0000, "R12 unmapped read");
        wr(4'd0, 8'hFF);
        rd(4'd0, 16'h0011, "R12 write to raw ignored");
        rd(4'd1, 16'h0010, "R12 mask unchanged");

        repeat (3) @(posedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errs++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errs++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule